// File: doc/BRIEF.md
# ULPI link-side bus controller

This block sits on the link side of a 12-signal ULPI connection to a USB PHY. All of its logic runs on the PHY's 60 MHz clock. It watches the direction input to learn who owns the 8-bit data bus. It inserts a one-cycle turnaround whenever ownership changes. While the link owns the bus, it drives the bus. While the PHY owns the bus, it samples the bus.

On the transmit side, a local byte stream with valid, ready and last-byte signals is turned into a ULPI transmit transfer. Each byte is held until the PHY accepts it with NXT. One STP cycle follows the final byte. A separate request port performs single register writes. A write sends a command byte, then a data byte, then STP. A transceiver reset, for example, is a write of 0x20 to address 0x04. If the PHY takes the bus during a transfer, the block abandons the transfer and reports an abort.

On the receive side, bytes that the PHY drives are split into two kinds. A byte seen with NXT high is forwarded as receive data. A byte seen with NXT low is latched as a receive status byte.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: While reset is held and the direction input is low, the block drives the bus (output enable 1) with 0x00, STP is 0, and no receive pulse is shown.
- R2: While the direction input is high, the output enable is 0. No transfer starts until the direction input has been low for a full cycle; the first link-owned cycle after that shows the idle byte 0x00.
- R3: In the first cycle after the direction input changes level, the output enable is 0, and a byte the PHY drives in the first cycle after the direction input rises is not captured.
- R4: During a stream the bus carries the current tx_data byte. tx_ready is 1 only in cycles where NXT is 1 and the link owns the bus, so a byte is held while NXT is 0.
- R5: In the cycle after NXT accepts the byte flagged last, STP is 1 for exactly one cycle and the bus carries 0x00; the cycle after that is idle again.
- R6: A register write drives the command byte {2'b10, address[5:0]} (bit 7 is the MSB) until NXT accepts it, then drives the data byte until NXT accepts it, then asserts STP for one cycle with reg_wr_done 1 in that same cycle.
- R7: When a register write request and stream data are both pending in an idle cycle, the register write goes first; the stream starts after it ends, and its STP cycle shows reg_wr_done 0.
- R8: If the direction input rises during a stream or a register write, tx_abort is 1 and the output enable is 0 in that same cycle, and the block returns to idle.
- R9: A byte on the bus while the PHY owns it (past turnaround) with NXT 1 appears on rx_data with a one-cycle rx_valid pulse in the next cycle.
- R10: A byte on the bus while the PHY owns it with NXT 0 is latched on rxcmd with a one-cycle rxcmd_valid pulse in the next cycle, and rx_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz clock from the PHY, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ulpi_dir | input | 1 | Bus direction from the PHY; 1 means the PHY owns the bus |
| ulpi_nxt | input | 1 | PHY strobe: byte accepted (transmit) or data byte (receive) |
| ulpi_data_i | input | 8 | Data bus as seen at the pins |
| ulpi_data_o | output | 8 | Data the link drives onto the bus |
| ulpi_data_oe | output | 1 | Drive enable for ulpi_data_o |
| ulpi_stp | output | 1 | Stop marker after the final transmitted byte |
| tx_valid | input | 1 | Local stream byte present |
| tx_data | input | 8 | Local stream byte; the first byte is the transmit command |
| tx_last | input | 1 | Marks the final byte of the stream |
| tx_ready | output | 1 | Current stream byte consumed at this edge |
| tx_abort | output | 1 | Pulse: the transfer was abandoned because the PHY took the bus |
| reg_wr_req | input | 1 | Register write request, held until done |
| reg_addr | input | 6 | Register address |
| reg_wr_data | input | 8 | Register write value |
| reg_wr_done | output | 1 | Pulse in the STP cycle that ends a register write |
| rx_valid | output | 1 | Pulse: rx_data holds a new received byte |
| rx_data | output | 8 | Received data byte |
| rxcmd_valid | output | 1 | Pulse: rxcmd holds a new status byte |
| rxcmd | output | 8 | Last received status byte |

## Verification
The bus drive, output enable, STP, tx_ready, tx_abort and reg_wr_done outputs are decoded from the current state and the present inputs, so they are due in the same cycle as the input that causes them. A state change caused by an input at an edge shows one cycle later. The receive outputs are registered, so they are due one cycle after the edge that samples the bus. The bench applies each cycle's inputs at the falling edge and samples 1 ns later. Each expectation is therefore stated for the cycle whose inputs are currently applied, and state and capture effects are expected in the following cycle.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TX    = 3'd1,
    ST_RCMD  = 3'd2,
    ST_RDATA = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  localparam logic [1:0] REG_WRITE_PREFIX = 2'b10;
endpackage

// File: rtl/ulpi_dir_track.sv
module ulpi_dir_track (
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  output logic link_owns,
  output logic phy_owns
);
  logic dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir;
  end

  // Ownership counts only after a full cycle at the same level.
  assign link_owns = !dir && !dir_q;
  assign phy_owns  = dir && dir_q;
endmodule

// File: rtl/ulpi_tx_engine.sv
module ulpi_tx_engine
  import ulpi_link_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_owns,
  input  logic          dir,
  input  logic          nxt,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_last,
  input  logic          reg_wr_req,
  input  logic [DW-3:0] reg_addr,
  input  logic [DW-1:0] reg_wr_data,
  output logic [DW-1:0] dout,
  output logic          stp,
  output logic          tx_ready,
  output logic          tx_abort,
  output logic          reg_wr_done
);
  localparam int AW = DW - 2;

  function automatic logic [DW-1:0] wr_cmd(input logic [AW-1:0] a);
    return {REG_WRITE_PREFIX, a};
  endfunction

  tx_state_e state_q, state_d;
  logic      is_reg_q;

  always_comb begin
    state_d  = state_q;
    tx_abort = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (link_owns) begin
          if (reg_wr_req)    state_d = ST_RCMD;
          else if (tx_valid) state_d = ST_TX;
        end
      end
      ST_TX: begin
        if (dir) begin
          tx_abort = 1'b1;
          state_d  = ST_IDLE;
        end else if (nxt && tx_valid && tx_last) begin
          state_d = ST_STOP;
        end
      end
      ST_RCMD: begin
        if (dir) begin
          tx_abort = 1'b1;
          state_d  = ST_IDLE;
        end else if (nxt) begin
          state_d = ST_RDATA;
        end
      end
      ST_RDATA: begin
        if (dir) begin
          tx_abort = 1'b1;
          state_d  = ST_IDLE;
        end else if (nxt) begin
          state_d = ST_STOP;
        end
      end
      ST_STOP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      is_reg_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) is_reg_q <= reg_wr_req;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_TX:    dout = tx_data;
      ST_RCMD:  dout = wr_cmd(reg_addr);
      ST_RDATA: dout = reg_wr_data;
      default:  dout = '0;
    endcase
  end

  assign stp         = (state_q == ST_STOP);
  assign tx_ready    = (state_q == ST_TX) && nxt && link_owns;
  assign reg_wr_done = stp && is_reg_q;

  // R5: the stop marker lasts one cycle only
  p_stp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stp |=> !stp);
  // R5: a stop marker always follows a byte accepted by the PHY
  p_stp_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stp |-> $past(nxt));
  // R4: a byte is consumed only when the bus was ours in the prior cycle
  p_ready_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !$past(dir));
  // R8: an abort always leaves the engine idle
  p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> (state_q == ST_IDLE));
endmodule

// File: rtl/ulpi_rx_capture.sv
module ulpi_rx_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phy_owns,
  input  logic          nxt,
  input  logic [DW-1:0] din,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rxcmd_valid,
  output logic [DW-1:0] rxcmd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid    <= 1'b0;
      rx_data     <= '0;
      rxcmd_valid <= 1'b0;
      rxcmd       <= '0;
    end else begin
      rx_valid    <= phy_owns && nxt;
      rxcmd_valid <= phy_owns && !nxt;
      if (phy_owns && nxt)  rx_data <= din;
      if (phy_owns && !nxt) rxcmd   <= din;
    end
  end

  // R10: a status pulse never coincides with a data pulse
  p_rx_kinds_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rxcmd_valid));
endmodule

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ulpi_dir,
  input  logic          ulpi_nxt,
  input  logic [DW-1:0] ulpi_data_i,
  output logic [DW-1:0] ulpi_data_o,
  output logic          ulpi_data_oe,
  output logic          ulpi_stp,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_last,
  output logic          tx_ready,
  output logic          tx_abort,
  input  logic          reg_wr_req,
  input  logic [DW-3:0] reg_addr,
  input  logic [DW-1:0] reg_wr_data,
  output logic          reg_wr_done,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rxcmd_valid,
  output logic [DW-1:0] rxcmd
);
  logic link_owns;
  logic phy_owns;

  ulpi_dir_track u_dir (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir       (ulpi_dir),
    .link_owns (link_owns),
    .phy_owns  (phy_owns)
  );

  ulpi_tx_engine #(.DW(DW)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_owns   (link_owns),
    .dir         (ulpi_dir),
    .nxt         (ulpi_nxt),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .reg_wr_req  (reg_wr_req),
    .reg_addr    (reg_addr),
    .reg_wr_data (reg_wr_data),
    .dout        (ulpi_data_o),
    .stp         (ulpi_stp),
    .tx_ready    (tx_ready),
    .tx_abort    (tx_abort),
    .reg_wr_done (reg_wr_done)
  );

  ulpi_rx_capture #(.DW(DW)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .phy_owns    (phy_owns),
    .nxt         (ulpi_nxt),
    .din         (ulpi_data_i),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rxcmd_valid (rxcmd_valid),
    .rxcmd       (rxcmd)
  );

  assign ulpi_data_oe = link_owns;

  // R3: the bus is released in any cycle where direction has just changed
  p_turn_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ulpi_dir != $past(ulpi_dir)) |-> !ulpi_data_oe);
  // R3: received data only after the PHY has held the bus past turnaround
  p_rx_after_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(ulpi_dir) && $past(ulpi_dir, 2)));
endmodule

// File: tb/ulpi_link_ctrl_test.sv
module ulpi_link_ctrl_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ulpi_dir, ulpi_nxt;
  logic [DW-1:0] ulpi_data_i, ulpi_data_o;
  logic          ulpi_data_oe, ulpi_stp;
  logic          tx_valid, tx_last, tx_ready, tx_abort;
  logic [DW-1:0] tx_data;
  logic          reg_wr_req, reg_wr_done;
  logic [DW-3:0] reg_addr;
  logic [DW-1:0] reg_wr_data;
  logic          rx_valid, rxcmd_valid;
  logic [DW-1:0] rx_data, rxcmd;

  always #2 clk = ~clk;

  ulpi_link_ctrl #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
    .ulpi_data_i(ulpi_data_i), .ulpi_data_o(ulpi_data_o),
    .ulpi_data_oe(ulpi_data_oe), .ulpi_stp(ulpi_stp),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .tx_abort(tx_abort),
    .reg_wr_req(reg_wr_req), .reg_addr(reg_addr), .reg_wr_data(reg_wr_data),
    .reg_wr_done(reg_wr_done), .rx_valid(rx_valid), .rx_data(rx_data),
    .rxcmd_valid(rxcmd_valid), .rxcmd(rxcmd)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Stream table: {nxt, valid, last, tx_data, exp_stp, exp_ready, exp_dout}
  localparam logic [20:0] TXV [8] = '{
    {1'b0, 1'b1, 1'b0, 8'h41, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h41, 1'b0, 1'b0, 8'h41},
    {1'b1, 1'b1, 1'b0, 8'h41, 1'b0, 1'b1, 8'h41},
    {1'b1, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5},
    {1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, 8'h3C},
    {1'b1, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, 8'h3C},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ulpi_dir = 1'b0; ulpi_nxt = 1'b0; ulpi_data_i = '0;
    tx_valid = 1'b0; tx_data = '0; tx_last = 1'b0;
    reg_wr_req = 1'b0; reg_addr = '0; reg_wr_data = '0;
    #1;
    // R1 reset state
    chk("R1 oe", {7'b0, ulpi_data_oe}, 8'h01);
    chk("R1 dout", ulpi_data_o, 8'h00);
    chk("R1 stp", {7'b0, ulpi_stp}, 8'h00);
    chk("R1 rx_valid", {7'b0, rx_valid}, 8'h00);
    repeat (3) next_cycle();
    rst_n = 1'b1;
    repeat (2) next_cycle();

    // R4 R5 stream table walk
    for (int i = 0; i < 8; i++) begin
      ulpi_nxt = TXV[i][20]; tx_valid = TXV[i][19];
      tx_last  = TXV[i][18]; tx_data  = TXV[i][17:10];
      #1;
      chk($sformatf("R4 dout step %0d", i), ulpi_data_o, TXV[i][7:0]);
      chk($sformatf("R4 ready step %0d", i), {7'b0, tx_ready}, {7'b0, TXV[i][8]});
      chk($sformatf("R5 stp step %0d", i), {7'b0, ulpi_stp}, {7'b0, TXV[i][9]});
      next_cycle();
    end

    // R6 transceiver reset write: address 0x04, value 0x20
    reg_wr_req = 1'b1; reg_addr = 6'h04; reg_wr_data = 8'h20; ulpi_nxt = 1'b0;
    #1; chk("R6 idle before cmd", ulpi_data_o, 8'h00);
    next_cycle(); #1;
    chk("R6 cmd held", ulpi_data_o, 8'h84);
    next_cycle(); ulpi_nxt = 1'b1; #1;
    chk("R6 cmd accepted", ulpi_data_o, 8'h84);
    next_cycle(); #1;
    chk("R6 data byte", ulpi_data_o, 8'h20);
    next_cycle(); ulpi_nxt = 1'b0; #1;
    chk("R6 stp", {7'b0, ulpi_stp}, 8'h01);
    chk("R6 done", {7'b0, reg_wr_done}, 8'h01);
    chk("R6 stp dout", ulpi_data_o, 8'h00);
    next_cycle(); reg_wr_req = 1'b0; #1;
    chk("R6 stp ends", {7'b0, ulpi_stp}, 8'h00);
    next_cycle();

    // R7 write wins over pending stream
    reg_wr_req = 1'b1; reg_addr = 6'h3F; reg_wr_data = 8'h5A;
    tx_valid = 1'b1; tx_data = 8'h11; tx_last = 1'b1;
    next_cycle(); ulpi_nxt = 1'b1; #1;
    chk("R7 cmd first", ulpi_data_o, 8'hBF);
    next_cycle(); #1;
    chk("R7 data", ulpi_data_o, 8'h5A);
    next_cycle(); ulpi_nxt = 1'b0; #1;
    chk("R7 write done", {7'b0, reg_wr_done}, 8'h01);
    next_cycle(); reg_wr_req = 1'b0; #1;
    chk("R7 idle gap", ulpi_data_o, 8'h00);
    next_cycle(); ulpi_nxt = 1'b1; #1;
    chk("R7 stream after", ulpi_data_o, 8'h11);
    chk("R7 stream ready", {7'b0, tx_ready}, 8'h01);
    next_cycle(); ulpi_nxt = 1'b0; tx_valid = 1'b0; tx_last = 1'b0; #1;
    chk("R7 stream stp", {7'b0, ulpi_stp}, 8'h01);
    chk("R7 stream not write", {7'b0, reg_wr_done}, 8'h00);
    next_cycle();

    // R2 no start while PHY holds the bus
    ulpi_dir = 1'b1; tx_valid = 1'b1; tx_data = 8'h66; #1;
    chk("R2 released", {7'b0, ulpi_data_oe}, 8'h00);
    repeat (3) next_cycle();
    #1; chk("R2 still released", {7'b0, ulpi_data_oe}, 8'h00);
    next_cycle(); ulpi_dir = 1'b0; #1;
    chk("R3 turnaround after fall", {7'b0, ulpi_data_oe}, 8'h00);
    next_cycle(); #1;
    chk("R2 first owned oe", {7'b0, ulpi_data_oe}, 8'h01);
    chk("R2 first owned idle", ulpi_data_o, 8'h00);
    next_cycle(); #1;
    chk("R2 start after free", ulpi_data_o, 8'h66);

    // R8 abort, then receive R3 R9 R10
    next_cycle(); ulpi_dir = 1'b1; ulpi_nxt = 1'b1; ulpi_data_i = 8'h77; tx_valid = 1'b0; #1;
    chk("R8 abort pulse", {7'b0, tx_abort}, 8'h01);
    chk("R8 released", {7'b0, ulpi_data_oe}, 8'h00);
    chk("R8 no ready", {7'b0, tx_ready}, 8'h00);
    next_cycle(); ulpi_data_i = 8'h5A; #1;
    chk("R3 turnaround byte dropped", {7'b0, rx_valid}, 8'h00);
    chk("R8 abort one cycle", {7'b0, tx_abort}, 8'h00);
    next_cycle(); ulpi_nxt = 1'b0; ulpi_data_i = 8'h4E; #1;
    chk("R9 rx_valid", {7'b0, rx_valid}, 8'h01);
    chk("R9 rx_data", rx_data, 8'h5A);
    next_cycle(); ulpi_data_i = 8'h00; #1;
    chk("R10 rxcmd_valid", {7'b0, rxcmd_valid}, 8'h01);
    chk("R10 rxcmd", rxcmd, 8'h4E);
    chk("R10 no data pulse", {7'b0, rx_valid}, 8'h00);
    next_cycle(); ulpi_dir = 1'b0; #1;
    chk("R3 release on fall", {7'b0, ulpi_data_oe}, 8'h00);
    next_cycle(); #1;
    chk("R8 idle after abort", ulpi_data_o, 8'h00);
    chk("R8 idle stp", {7'b0, ulpi_stp}, 8'h00);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule